// File: doc/BRIEF.md
# Raster Timing Counter

This block keeps the raster position for an image-sensor timing path. It has two cascaded counters, both clocked by the master clock. The pixel counter tracks the position inside a line. The line counter tracks the position inside a field. Every other piece of timing logic compares against these two counts to place its own edges, so both counts are exported.

In master mode the block generates its own active-low line sync and field sync from programmed lengths and pulse widths. In slave mode it takes line and field sync from outside and re-aligns its counters to their falling edges. In either mode, a rising edge on the restart input returns both counters to the first pixel of the first line.

All sync inputs pass through a two-flop synchroniser and an edge detector. Mode and lengths arrive as parallel configuration inputs. They are held in a shadow copy that is reloaded only when a field begins, so a line is never cut short partway through.

Top module: `raster_timing`

## Requirements
- R1: While reset is held, pixel and line counts are 0, the mode is master, and the shadow settings hold their parameter defaults (line last 1599, field last 1199, line-sync width 64, field-sync width 4). Both sync outputs are therefore low.
- R2: In master mode the pixel count advances by one each clock. On the clock after it equals (or exceeds) the programmed line-last value (line length minus one), it returns to 0.
- R3: In master mode the line count advances by one when the pixel count wraps. It returns to 0 when it wraps while at or above the programmed field-last value. A field therefore has field-last + 1 lines.
- R4: In master mode `hd_out_n` is low exactly while the pixel count is below the programmed line-sync width. A width of 0 keeps it high.
- R5: In master mode `vd_out_n` is low exactly while the line count is below the programmed field-sync width.
- R6: Suppose `ext_sync` is sampled high at clock edge k after being low at edge k-1. Then both counts are 0 after edge k+2, and a new field begins. This holds in either mode.
- R7: Configuration inputs are copied into the working settings only on the edge where a new field begins: a master field wrap, a restart, or a slave field-sync edge. At any other time they have no effect on the counts or the sync outputs.
- R8: In slave mode, suppose `hd_in` is sampled low at edge k after being high at edge k-1. Then after edge k+2 the pixel count is 0 and the line count has advanced by one. The line count returns to 0 if it was at or above field-last.
- R9: In slave mode, a falling edge on `vd_in` (same sampling as R8) sets the line count to 0 after edge k+2 and begins a new field.
- R10: In slave mode, without a line-sync edge the pixel count advances by one each clock and holds at 8191. Both sync outputs stay high.
- R11: A change of `cfg_slave` takes effect only at the next field start, together with the other settings.
- R12: The counters are 13 bits wide. A line-last value of 8191 gives lines of 8192 pixels, and the pixel count reaches 8191 before it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 1 selects slave operation, 0 selects master |
| cfg_line_last | input | 13 | Line length minus one, in pixels |
| cfg_field_last | input | 13 | Field length minus one, in lines |
| cfg_hd_width | input | 13 | Line-sync low width in pixels (master) |
| cfg_vd_width | input | 13 | Field-sync low width in lines (master) |
| ext_sync | input | 1 | Restart request, rising-edge active, asynchronous |
| hd_in | input | 1 | External line sync, falling-edge active (slave) |
| vd_in | input | 1 | External field sync, falling-edge active (slave) |
| hd_out_n | output | 1 | Generated line sync, active low |
| vd_out_n | output | 1 | Generated field sync, active low |
| pix_cnt | output | 13 | Current pixel position in the line |
| line_cnt | output | 13 | Current line position in the field |

## Verification
A wrong pixel count appears on `pix_cnt` in the very cycle it goes wrong. Within one line it also moves the `hd_out_n` edges and shifts the next line-count step. A corrupted shadow setting or mode bit cannot be seen until the field start that should have loaded it, so the bench changes settings in mid-field and follows the outputs through the next wrap. Synchroniser latency errors show up as a one-cycle shift of the restart, line-sync or field-sync alignment. The bench compares every cycle, so such a shift fails on its first cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;

   typedef enum logic {
      MODE_MASTER = 1'b0,
      MODE_SLAVE  = 1'b1
   } raster_mode_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   localparam int unsigned RASTER_CNT_W = 13;

endpackage

// File: rtl/raster_edge_sync.sv
module raster_edge_sync #(
   parameter int unsigned            STAGES = 2,
   parameter raster_pkg::edge_kind_e EDGE   = raster_pkg::EDGE_RISE,
   parameter logic                   IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);

   localparam int unsigned LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("raster_edge_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {(LAST + 1){IDLE}};
      else        chain_q <= {chain_q[LAST-1:0], din};
   end

   if (EDGE == raster_pkg::EDGE_RISE) begin : g_rise
      assign pulse = chain_q[LAST-1] & ~chain_q[LAST];
   end else begin : g_fall
      assign pulse = ~chain_q[LAST-1] & chain_q[LAST];
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R6

endmodule

// File: rtl/raster_cfg_shadow.sv
module raster_cfg_shadow #(
   parameter int unsigned     W          = 13,
   parameter logic            DEF_SLAVE  = 1'b0,
   parameter logic [W-1:0]    DEF_LLAST  = '0,
   parameter logic [W-1:0]    DEF_FLAST  = '0,
   parameter logic [W-1:0]    DEF_HWIDTH = '0,
   parameter logic [W-1:0]    DEF_VWIDTH = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         slave_i,
   input  logic [W-1:0] llast_i,
   input  logic [W-1:0] flast_i,
   input  logic [W-1:0] hwidth_i,
   input  logic [W-1:0] vwidth_i,
   output raster_pkg::raster_mode_e mode_o,
   output logic [W-1:0] llast_o,
   output logic [W-1:0] flast_o,
   output logic [W-1:0] hwidth_o,
   output logic [W-1:0] vwidth_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o   <= raster_pkg::raster_mode_e'(DEF_SLAVE);
         llast_o  <= DEF_LLAST;
         flast_o  <= DEF_FLAST;
         hwidth_o <= DEF_HWIDTH;
         vwidth_o <= DEF_VWIDTH;
      end else if (load) begin
         mode_o   <= raster_pkg::raster_mode_e'(slave_i);
         llast_o  <= llast_i;
         flast_o  <= flast_i;
         hwidth_o <= hwidth_i;
         vwidth_o <= vwidth_i;
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(llast_o) && $stable(flast_o) && $stable(hwidth_o)
                 && $stable(vwidth_o) && $stable(mode_o))); // R7

   AST_MODE_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && slave_i) |=> (mode_o == raster_pkg::MODE_SLAVE)); // R11

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
   parameter int unsigned W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  raster_pkg::raster_mode_e mode,
   input  logic [W-1:0] llast,
   input  logic [W-1:0] flast,
   input  logic         restart_evt,
   input  logic         hsync_evt,
   input  logic         vsync_evt,
   output logic [W-1:0] pix_q,
   output logic [W-1:0] line_q,
   output logic         field_start
);

   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] ONE     = W'(1);

   logic [W-1:0] pix_d, line_d;
   logic [W-1:0] line_adv;

   assign line_adv = (line_q >= flast) ? '0 : line_q + ONE;

   always_comb begin
      pix_d       = pix_q;
      line_d      = line_q;
      field_start = 1'b0;
      if (restart_evt) begin
         pix_d       = '0;
         line_d      = '0;
         field_start = 1'b1;
      end else if (mode == raster_pkg::MODE_SLAVE) begin
         if (hsync_evt) begin
            pix_d  = '0;
            line_d = line_adv;
         end else if (pix_q != CNT_MAX) begin
            pix_d = pix_q + ONE;
         end
         if (vsync_evt) begin
            line_d      = '0;
            field_start = 1'b1;
         end
      end else begin
         if (pix_q >= llast) begin
            pix_d       = '0;
            line_d      = line_adv;
            field_start = (line_q >= flast);
         end else begin
            pix_d = pix_q + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         line_q <= '0;
      end else begin
         pix_q  <= pix_d;
         line_q <= line_d;
      end
   end

   AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_MASTER && !restart_evt && pix_q < llast)
      |=> (pix_q == $past(pix_q) + ONE)); // R2

   AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_MASTER && pix_q == llast) |=> (pix_q == '0)); // R2

   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_MASTER && !restart_evt && pix_q < llast)
      |=> $stable(line_q)); // R3

   AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      restart_evt |=> (pix_q == '0 && line_q == '0)); // R6

   AST_SLAVE_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_SLAVE && hsync_evt && !restart_evt)
      |=> (pix_q == '0)); // R8

   AST_SLAVE_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_SLAVE && vsync_evt) |=> (line_q == '0)); // R9

   AST_SLAVE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == raster_pkg::MODE_SLAVE && !hsync_evt && !restart_evt && pix_q == CNT_MAX)
      |=> (pix_q == CNT_MAX)); // R10

endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
   parameter int unsigned CNT_W          = raster_pkg::RASTER_CNT_W,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic        DEF_SLAVE      = 1'b0,
   parameter int unsigned DEF_LINE_LAST  = 1599,
   parameter int unsigned DEF_FIELD_LAST = 1199,
   parameter int unsigned DEF_HD_WIDTH   = 64,
   parameter int unsigned DEF_VD_WIDTH   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_slave,
   input  logic [CNT_W-1:0] cfg_line_last,
   input  logic [CNT_W-1:0] cfg_field_last,
   input  logic [CNT_W-1:0] cfg_hd_width,
   input  logic [CNT_W-1:0] cfg_vd_width,
   input  logic             ext_sync,
   input  logic             hd_in,
   input  logic             vd_in,
   output logic             hd_out_n,
   output logic             vd_out_n,
   output logic [CNT_W-1:0] pix_cnt,
   output logic [CNT_W-1:0] line_cnt
);

   localparam longint unsigned CNT_SPAN = 64'd1 << CNT_W;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("raster_timing: CNT_W out of range");
   end
   if (DEF_LINE_LAST >= CNT_SPAN || DEF_FIELD_LAST >= CNT_SPAN ||
       DEF_HD_WIDTH >= CNT_SPAN || DEF_VD_WIDTH >= CNT_SPAN) begin : g_bad_default
      $error("raster_timing: a default setting does not fit CNT_W");
   end

   raster_pkg::raster_mode_e mode;
   logic [CNT_W-1:0] llast, flast, hwidth, vwidth;
   logic restart_evt, hsync_evt, vsync_evt, field_start;

   raster_edge_sync #(.STAGES(SYNC_STAGES), .EDGE(raster_pkg::EDGE_RISE), .IDLE(1'b0))
      i_restart_sync (.clk(clk), .rst_n(rst_n), .din(ext_sync), .pulse(restart_evt));

   raster_edge_sync #(.STAGES(SYNC_STAGES), .EDGE(raster_pkg::EDGE_FALL), .IDLE(1'b1))
      i_hsync_sync (.clk(clk), .rst_n(rst_n), .din(hd_in), .pulse(hsync_evt));

   raster_edge_sync #(.STAGES(SYNC_STAGES), .EDGE(raster_pkg::EDGE_FALL), .IDLE(1'b1))
      i_vsync_sync (.clk(clk), .rst_n(rst_n), .din(vd_in), .pulse(vsync_evt));

   raster_cfg_shadow #(
      .W(CNT_W),
      .DEF_SLAVE(DEF_SLAVE),
      .DEF_LLAST(CNT_W'(DEF_LINE_LAST)),
      .DEF_FLAST(CNT_W'(DEF_FIELD_LAST)),
      .DEF_HWIDTH(CNT_W'(DEF_HD_WIDTH)),
      .DEF_VWIDTH(CNT_W'(DEF_VD_WIDTH))
   ) i_shadow (
      .clk(clk), .rst_n(rst_n), .load(field_start),
      .slave_i(cfg_slave), .llast_i(cfg_line_last), .flast_i(cfg_field_last),
      .hwidth_i(cfg_hd_width), .vwidth_i(cfg_vd_width),
      .mode_o(mode), .llast_o(llast), .flast_o(flast),
      .hwidth_o(hwidth), .vwidth_o(vwidth)
   );

   raster_counter #(.W(CNT_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .mode(mode), .llast(llast), .flast(flast),
      .restart_evt(restart_evt), .hsync_evt(hsync_evt), .vsync_evt(vsync_evt),
      .pix_q(pix_cnt), .line_q(line_cnt), .field_start(field_start)
   );

   assign hd_out_n = !(mode == raster_pkg::MODE_MASTER && pix_cnt  < hwidth);
   assign vd_out_n = !(mode == raster_pkg::MODE_MASTER && line_cnt < vwidth);

   AST_FIELD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> (line_cnt == '0)); // R3

   AST_SLAVE_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && cfg_slave) |=> (hd_out_n && vd_out_n)); // R10

endmodule

// File: tb/test_raster_timing.sv
module test_raster_timing;

   localparam time CYC = 4ns;
   localparam int  W   = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tb_slave = 1'b0;
   logic [W-1:0] tb_ll = 13'd1599, tb_fl = 13'd1199, tb_hw = 13'd64, tb_vw = 13'd4;
   logic tb_sync = 1'b0, tb_hd = 1'b1, tb_vd = 1'b1;
   logic hd_out_n, vd_out_n;
   logic [W-1:0] pix_cnt, line_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CYC/2) clk = ~clk;

   raster_timing i_raster_timing (
      .clk(clk), .rst_n(rst_n), .cfg_slave(tb_slave),
      .cfg_line_last(tb_ll), .cfg_field_last(tb_fl),
      .cfg_hd_width(tb_hw), .cfg_vd_width(tb_vw),
      .ext_sync(tb_sync), .hd_in(tb_hd), .vd_in(tb_vd),
      .hd_out_n(hd_out_n), .vd_out_n(vd_out_n),
      .pix_cnt(pix_cnt), .line_cnt(line_cnt)
   );

   typedef struct {
      logic [W-1:0] p;
      logic [W-1:0] l;
      logic         h;
      logic         v;
      string        tag;
   } exp_t;

   exp_t exp_q[$];

   // expected state built from the requirements
   logic [W-1:0] ep = '0, el = '0;
   logic         m_slave = 1'b0;
   logic [W-1:0] m_ll = 13'd1599, m_fl = 13'd1199, m_hw = 13'd64, m_vw = 13'd4;
   logic [2:0]   hs = 3'b000, hh = 3'b111, hv = 3'b111;

   function automatic exp_t make_exp(string tag);
      exp_t e;
      e.p = ep;
      e.l = el;
      e.h = !(!m_slave && ep < m_hw);
      e.v = !(!m_slave && el < m_vw);
      e.tag = tag;
      return e;
   endfunction

   task automatic model_step();
      logic sev, hev, vev, fs;
      logic [W-1:0] ladv;
      sev = hs[1] & ~hs[2];
      hev = ~hh[1] & hh[2];
      vev = ~hv[1] & hv[2];
      hs = {hs[1:0], tb_sync};
      hh = {hh[1:0], tb_hd};
      hv = {hv[1:0], tb_vd};
      fs = 1'b0;
      ladv = (el >= m_fl) ? '0 : el + 13'd1;
      if (sev) begin
         ep = '0; el = '0; fs = 1'b1;
      end else if (m_slave) begin
         if (hev) begin ep = '0; el = ladv; end
         else if (ep != 13'h1FFF) ep = ep + 13'd1;
         if (vev) begin el = '0; fs = 1'b1; end
      end else if (ep >= m_ll) begin
         fs = (el >= m_fl);
         ep = '0;
         el = ladv;
      end else begin
         ep = ep + 13'd1;
      end
      if (fs) begin
         m_slave = tb_slave; m_ll = tb_ll; m_fl = tb_fl; m_hw = tb_hw; m_vw = tb_vw;
      end
   endtask

   // driver: one clock, model follows, expectation queued
   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      exp_q.push_back(make_exp(tag));
      #1;
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (pix_cnt !== e.p || line_cnt !== e.l || hd_out_n !== e.h || vd_out_n !== e.v) begin
            fails++;
            $display("FAIL [%s] pix=%0d line=%0d hd_n=%0b vd_n=%0b expected pix=%0d line=%0d hd_n=%0b vd_n=%0b",
                     e.tag, pix_cnt, line_cnt, hd_out_n, vd_out_n, e.p, e.l, e.h, e.v);
         end
      end
   end

   task automatic restart(string tag);
      tb_sync = 1'b1; cyc(tag);
      tb_sync = 1'b0; cyc(tag);
   endtask

   task automatic hd_edge(string tag);
      tb_hd = 1'b0; run(2, tag);
      tb_hd = 1'b1;
   endtask

   initial begin
      // R1: reset state
      @(posedge clk); #1;
      exp_q.push_back(make_exp("R1"));
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R6 R2 R3 R4 R5: restart loads short master settings, then free running
      tb_ll = 13'd9; tb_fl = 13'd4; tb_hw = 13'd3; tb_vw = 13'd2;
      restart("R6");
      run(150, "R2 R3 R4 R5");

      // R7: settings change mid-field, old settings kept until the field wraps
      run(7, "R7");
      tb_ll = 13'd5; tb_fl = 13'd3; tb_hw = 13'd0; tb_vw = 13'd1;
      run(120, "R7 R4 R5");

      // R6: restart in the middle of a field
      run(9, "R6");
      restart("R6");
      run(30, "R6 R2");

      // R11: request slave mode mid-field; it applies at the next field start
      tb_slave = 1'b1;
      for (int i = 0; i < 200 && !m_slave; i++) cyc("R11");
      run(3, "R11 R10");

      // R8 R9: externally timed lines and fields
      for (int ln = 0; ln < 6; ln++) begin
         run(7, "R8 R10");
         if (ln == 3) tb_vd = 1'b0;
         hd_edge("R8 R9");
         tb_vd = 1'b1;
      end
      tb_vd = 1'b0; run(2, "R9");
      tb_vd = 1'b1;
      run(5, "R9");

      // R10: no line sync, pixel count saturates
      run(8200, "R10");

      // R12 R11: back to master with full-width lines
      tb_slave = 1'b0; tb_ll = 13'd8191; tb_fl = 13'd1; tb_hw = 13'd100; tb_vw = 13'd1;
      tb_hd = 1'b0; tb_vd = 1'b0; run(2, "R11 R9");
      tb_hd = 1'b1; tb_vd = 1'b1;
      run(16400, "R12 R2 R3");
      restart("R6 R12");
      run(10, "R6");

      @(negedge clk); #1;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL [watchdog] run did not finish, got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule